// File: doc/BRIEF.md
# Byte-Sequenced Core Power Sequencer

This block takes a processor core into a low power state and back out again. It does so by interpreting a short program of single-byte commands, not through fixed logic. Software fills a 128-byte sequence memory and sets a control register through a simple register write port. The control register holds an enable bit and the index of the first command. When the core signals a wait-for-interrupt event, the interpreter fetches and executes one byte per clock. It drives a 7-bit bank of peripheral power control outputs, inserts short delays, and stalls on a wait command until the wake interrupt arrives. An end command finishes the program and pulses a release output, which frees the core from low power.

A status word can be read at any time. It reports the interpreter's state and the index it is currently pointing at. Software can therefore confirm where the sequence stands after any configuration change. The start index is copied when a sequence begins, so later register writes do not affect a program that is already running. The one exception is clearing the enable bit, which aborts the program at once.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset the enable bit is 0, the start index is 0, the control word and the status word read 0, `pwr_ctl_o` is 0, `release_o` is 0 and the state is idle.
- R2: The control word is at address 0x080. Bit 0 is the enable and bits 10:4 are the start index. A write to 0x080 replaces the whole word. A write to 0x081 replaces only bits 10:4, leaving every other control bit unchanged. Reading 0x080 returns the stored word.
- R3: While the enable bit is 0, a wait-for-interrupt pulse is ignored: the state stays idle and `pwr_ctl_o` keeps its value.
- R4: When the state is idle, the enable bit is 1 and `wfi_i` is high at a clock edge, the state becomes running from the programmed start index. From then on, one byte is executed per clock while running.
- R5: A byte with bit 7 set drives its low 7 bits onto `pwr_ctl_o` and advances the index. Bytes 0x10 to 0x7F are no-ops that only advance the index.
- R6: Byte 0x01 advances the index and enters the waiting state. The interpreter stays there until `wake_irq_i` is high at a clock edge, then continues with the next byte.
- R7: A byte N in the range 0x02 to 0x0F advances the index and holds execution in the delaying state for N clock cycles. After the wfi edge, a 0x04 byte followed by a power byte updates `pwr_ctl_o` 6 clock edges later.
- R8: Byte 0x00 returns the state to idle and raises `release_o` for exactly one clock cycle. `pwr_ctl_o` keeps its last value.
- R9: The sequence index wraps from 127 to 0.
- R10: The status word is at address 0x082. Bits 1:0 give the state (0 idle, 1 running, 2 waiting, 3 delaying) and bits 10:4 give the current sequence index. All other bits are 0.
- R11: Rewriting the control word while a sequence is active leaves the running sequence unchanged. Clearing the enable bit while a sequence is active returns the state to idle on the next clock and pulses `release_o` for one cycle.
- R12: Sequence byte k is written and read at address k (0x000 to 0x07F) through its low 8 data bits. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 9 | Write address (sequence bytes, control word, start field) |
| reg_wr_data | input | 32 | Write data |
| reg_rd_addr | input | 9 | Read address |
| reg_rd_data | output | 32 | Combinational read data |
| wfi_i | input | 1 | Core wait-for-interrupt event |
| wake_irq_i | input | 1 | Wake interrupt |
| pwr_ctl_o | output | 7 | Peripheral power control outputs |
| release_o | output | 1 | One-cycle pulse that takes the core out of low power |

## Verification
The bench builds the block with its default parameters: a 7-bit index, a 128-byte sequence memory and a 32-bit register word. At this size, a start index of 126 makes the index wrap to 0 within three bytes. The fixed start-field position at bits 10:4 allows the partial write to be checked against neighbouring control bits on both sides. The delay test counts clock edges to the power output update, so it pins down the exact cycle cost of a delay byte and of byte fetch.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int BYTE_W = 8;
  localparam int PWR_W  = BYTE_W - 1;
  localparam int CNT_W  = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DELAY = 2'd3
  } seq_state_e;

  typedef enum logic [2:0] {
    OP_END,
    OP_WAIT,
    OP_DELAY,
    OP_PWR,
    OP_NOP
  } op_kind_e;

  function automatic op_kind_e decode_op(input logic [BYTE_W-1:0] b);
    op_kind_e k;
    if (b[BYTE_W-1])                 k = OP_PWR;
    else if (b == 8'h00)             k = OP_END;
    else if (b == 8'h01)             k = OP_WAIT;
    else if (b[BYTE_W-2:CNT_W] == '0) k = OP_DELAY;
    else                             k = OP_NOP;
    return k;
  endfunction

endpackage

// File: rtl/pwr_seq_mem.sv
module pwr_seq_mem #(
  parameter int IDX_W = 7
) (
  input  logic                              clk,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [pwr_seq_pkg::BYTE_W-1:0]    wr_byte,
  input  logic [IDX_W-1:0]                  fetch_idx,
  output logic [pwr_seq_pkg::BYTE_W-1:0]    fetch_byte,
  input  logic [IDX_W-1:0]                  peek_idx,
  output logic [pwr_seq_pkg::BYTE_W-1:0]    peek_byte
);
  localparam int DEPTH = 1 << IDX_W;

  logic [pwr_seq_pkg::BYTE_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic cell_we;
    assign cell_we = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (cell_we) mem_q[g] <= wr_byte;
    end
  end

  assign fetch_byte = mem_q[fetch_idx];
  assign peek_byte  = mem_q[peek_idx];

endmodule

// File: rtl/pwr_seq_regs.sv
module pwr_seq_regs #(
  parameter int IDX_W     = 7,
  parameter int DATA_W    = 32,
  parameter int START_LSB = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W+1:0]               wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [IDX_W+1:0]               rd_addr,
  output logic [DATA_W-1:0]              rd_data,
  input  logic [1:0]                     stat_state,
  input  logic [IDX_W-1:0]               stat_idx,
  input  logic [pwr_seq_pkg::BYTE_W-1:0] mem_peek,
  output logic                           mem_we,
  output logic                           ctrl_en,
  output logic [IDX_W-1:0]               ctrl_start
);
  localparam int ADDR_W     = IDX_W + 2;
  localparam int DEPTH      = 1 << IDX_W;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(DEPTH);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(DEPTH + 2);

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] stat_word;
  logic              wr_is_mem, rd_is_mem;

  assign wr_is_mem = (wr_addr[ADDR_W-1:IDX_W] == 2'b00);
  assign rd_is_mem = (rd_addr[ADDR_W-1:IDX_W] == 2'b00);
  assign mem_we    = wr_en && wr_is_mem;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en && (wr_addr == A_CTRL)) begin
      ctrl_d = wr_data;
    end else if (wr_en && (wr_addr == A_START)) begin
      ctrl_d[START_LSB +: IDX_W] = wr_data[START_LSB +: IDX_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl_en    = ctrl_q[0];
  assign ctrl_start = ctrl_q[START_LSB +: IDX_W];

  always_comb begin
    stat_word = '0;
    stat_word[1:0] = stat_state;
    stat_word[START_LSB +: IDX_W] = stat_idx;
  end

  always_comb begin
    rd_data = '0;
    if (rd_is_mem)             rd_data = {{(DATA_W-pwr_seq_pkg::BYTE_W){1'b0}}, mem_peek};
    else if (rd_addr == A_CTRL) rd_data = ctrl_q;
    else if (rd_addr == A_STAT) rd_data = stat_word;
  end

endmodule

// File: rtl/pwr_seq_engine.sv
module pwr_seq_engine #(
  parameter int IDX_W = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           en,
  input  logic [IDX_W-1:0]               start_idx,
  input  logic                           wfi,
  input  logic                           wake,
  output logic [IDX_W-1:0]               fetch_idx,
  input  logic [pwr_seq_pkg::BYTE_W-1:0] fetch_byte,
  output logic [1:0]                     state,
  output logic [pwr_seq_pkg::PWR_W-1:0]  pwr,
  output logic                           rel
);
  import pwr_seq_pkg::*;

  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d, idx_inc;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PWR_W-1:0]  pwr_q, pwr_d;
  logic              rel_q, rel_d;
  op_kind_e          op;

  assign idx_inc = idx_q + {{(IDX_W-1){1'b0}}, 1'b1};
  assign op      = decode_op(fetch_byte);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    pwr_d   = pwr_q;
    rel_d   = 1'b0;
    if (state_q != ST_IDLE && !en) begin
      state_d = ST_IDLE;
      rel_d   = 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (en && wfi) begin
            state_d = ST_RUN;
            idx_d   = start_idx;
          end
        end
        ST_RUN: begin
          case (op)
            OP_END: begin
              state_d = ST_IDLE;
              rel_d   = 1'b1;
            end
            OP_WAIT: begin
              state_d = ST_WAIT;
              idx_d   = idx_inc;
            end
            OP_DELAY: begin
              state_d = ST_DELAY;
              cnt_d   = fetch_byte[CNT_W-1:0];
              idx_d   = idx_inc;
            end
            OP_PWR: begin
              pwr_d = fetch_byte[PWR_W-1:0];
              idx_d = idx_inc;
            end
            default: idx_d = idx_inc;
          endcase
        end
        ST_WAIT: begin
          if (wake) state_d = ST_RUN;
        end
        ST_DELAY: begin
          if (cnt_q == CNT_W'(1)) state_d = ST_RUN;
          else                    cnt_d   = cnt_q - CNT_W'(1);
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      pwr_q   <= '0;
      rel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      pwr_q   <= pwr_d;
      rel_q   <= rel_d;
    end
  end

  assign fetch_idx = idx_q;
  assign state     = state_q;
  assign pwr       = pwr_q;
  assign rel       = rel_q;

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top #(
  parameter int IDX_W     = 7,
  parameter int DATA_W    = 32,
  parameter int START_LSB = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr_en,
  input  logic [IDX_W+1:0]              reg_wr_addr,
  input  logic [DATA_W-1:0]             reg_wr_data,
  input  logic [IDX_W+1:0]              reg_rd_addr,
  output logic [DATA_W-1:0]             reg_rd_data,
  input  logic                          wfi_i,
  input  logic                          wake_irq_i,
  output logic [pwr_seq_pkg::PWR_W-1:0] pwr_ctl_o,
  output logic                          release_o
);
  import pwr_seq_pkg::*;

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              mem_we;
  logic              ctrl_en;
  logic [IDX_W-1:0]  ctrl_start;
  logic [IDX_W-1:0]  cur_idx;
  logic [BYTE_W-1:0] fetch_byte, peek_byte;
  logic [1:0]        eng_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  pwr_seq_regs #(.IDX_W(IDX_W), .DATA_W(DATA_W), .START_LSB(START_LSB)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_en      (reg_wr_en),
    .wr_addr    (reg_wr_addr),
    .wr_data    (reg_wr_data),
    .rd_addr    (reg_rd_addr),
    .rd_data    (reg_rd_data),
    .stat_state (eng_state),
    .stat_idx   (cur_idx),
    .mem_peek   (peek_byte),
    .mem_we     (mem_we),
    .ctrl_en    (ctrl_en),
    .ctrl_start (ctrl_start)
  );

  pwr_seq_mem #(.IDX_W(IDX_W)) u_mem (
    .clk        (clk),
    .wr_en      (mem_we),
    .wr_idx     (reg_wr_addr[IDX_W-1:0]),
    .wr_byte    (reg_wr_data[BYTE_W-1:0]),
    .fetch_idx  (cur_idx),
    .fetch_byte (fetch_byte),
    .peek_idx   (reg_rd_addr[IDX_W-1:0]),
    .peek_byte  (peek_byte)
  );

  pwr_seq_engine #(.IDX_W(IDX_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .en         (ctrl_en),
    .start_idx  (ctrl_start),
    .wfi        (wfi_i),
    .wake       (wake_irq_i),
    .fetch_idx  (cur_idx),
    .fetch_byte (fetch_byte),
    .state      (eng_state),
    .pwr        (pwr_ctl_o),
    .rel        (release_o)
  );

endmodule

// File: rtl/pwr_seq_checker.sv
module pwr_seq_checker #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [IDX_W-1:0] start_idx,
  input logic             wfi,
  input logic             wake,
  input logic [1:0]       state,
  input logic [IDX_W-1:0] idx,
  input logic [6:0]       pwr,
  input logic             rel
);
  // R3: disabled sequencer never leaves idle
  a_r3_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && !en) |=> (state == 2'd0));

  // R4: wfi while enabled starts at the programmed index
  a_r4_start_at_index: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && en && wfi) |=> (state == 2'd1 && idx == $past(start_idx)));

  // R6: waiting persists until wake
  a_r6_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && en && !wake) |=> (state == 2'd2 && $stable(idx)));

  // R8: release only coincides with idle, and lasts one cycle
  a_r8_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rel |-> (state == 2'd0));
  a_r8_release_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rel |=> !rel);

  // R5: power outputs only move while running
  a_r5_pwr_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 2'd1) |=> $stable(pwr));

  // R11: clearing enable aborts with release
  a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 2'd0 && !en) |=> (state == 2'd0 && rel));
endmodule

bind pwr_seq_top pwr_seq_checker #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .en        (ctrl_en),
  .start_idx (ctrl_start),
  .wfi       (wfi_i),
  .wake      (wake_irq_i),
  .state     (eng_state),
  .idx       (cur_idx),
  .pwr       (pwr_ctl_o),
  .rel       (release_o)
);

// File: tb/pwr_seq_top_bench.sv
module pwr_seq_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] A_CTRL  = 9'h080;
  localparam logic [8:0] A_START = 9'h081;
  localparam logic [8:0] A_STAT  = 9'h082;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [8:0]  reg_wr_addr;
  logic [31:0] reg_wr_data;
  logic [8:0]  reg_rd_addr;
  logic [31:0] reg_rd_data;
  logic        wfi_i, wake_irq_i;
  logic [6:0]  pwr_ctl_o;
  logic        release_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq_top u_pwr_seq_top (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .wfi_i(wfi_i), .wake_irq_i(wake_irq_i), .pwr_ctl_o(pwr_ctl_o), .release_o(release_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    reg_rd_addr = a;
    #1;
    d = reg_rd_data;
  endtask

  task automatic pulse_wfi();
    @(negedge clk); wfi_i = 1'b1;
    @(negedge clk); wfi_i = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake_irq_i = 1'b1;
    @(negedge clk); wake_irq_i = 1'b0;
  endtask

  // waits for release; returns edges waited (0 if never seen)
  task automatic wait_release(output int n);
    n = 0;
    for (int k = 1; k <= 100; k++) begin
      if (release_o) begin n = k; break; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CTRL, d); chk("R1", "ctrl after reset", d, 0);
    rd(A_STAT, d); chk("R1", "status after reset", d, 0);
    chk("R1", "pwr after reset", 32'(pwr_ctl_o), 0);
    chk("R1", "release after reset", 32'(release_o), 0);
  endtask

  task automatic t_mem_and_ctrl();
    logic [31:0] d;
    wr(9'h003, 32'hFFFF_FFA5);
    rd(9'h003, d); chk("R12", "sequence byte readback", d, 32'hA5);
    rd(9'h1FF, d); chk("R12", "unmapped read", d, 0);
    wr(A_CTRL, 32'h0000_A001);
    rd(A_CTRL, d); chk("R2", "full ctrl write", d, 32'h0000_A001);
    wr(A_START, 32'hFFFF_F7F0);
    rd(A_CTRL, d); chk("R2", "start field write keeps other bits", d, 32'h0000_A7F1);
    rd(A_STAT, d); chk("R10", "status idle after config", d, 0);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    wr(9'h005, 32'h83);
    wr(A_CTRL, 32'h0000_0050);
    pulse_wfi();
    repeat (3) @(negedge clk);
    rd(A_STAT, d); chk("R3", "state idle when disabled", d & 32'h3, 0);
    chk("R3", "pwr untouched when disabled", 32'(pwr_ctl_o), 0);
  endtask

  task automatic t_wait_seq();
    logic [31:0] d;
    int n;
    wr(9'h006, 32'h01); wr(9'h007, 32'h85); wr(9'h008, 32'h00);
    wr(A_CTRL, 32'h0000_0051);
    pulse_wfi();
    rd(A_STAT, d); chk("R4", "running at start index", d, 32'h0000_0051);
    @(negedge clk);
    chk("R5", "power byte drives outputs", 32'(pwr_ctl_o), 32'h03);
    @(negedge clk);
    rd(A_STAT, d); chk("R10", "waiting status with index 7", d, 32'h0000_0072);
    repeat (4) @(negedge clk);
    rd(A_STAT, d); chk("R6", "still waiting without wake", d, 32'h0000_0072);
    pulse_wake();
    wait_release(n);
    chk("R8", "release seen", 32'(n != 0), 1);
    chk("R6", "byte after wait executed", 32'(pwr_ctl_o), 32'h05);
    rd(A_STAT, d); chk("R8", "idle at end", d & 32'h3, 0);
    @(negedge clk);
    chk("R8", "release one cycle", 32'(release_o), 0);
  endtask

  task automatic t_delay();
    int n;
    wr(9'd20, 32'h04); wr(9'd21, 32'h81); wr(9'd22, 32'h00);
    wr(A_CTRL, 32'h0000_0141);
    pulse_wfi();
    n = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (pwr_ctl_o == 7'h01) begin n = k; break; end
    end
    chk("R7", "delay 4 edges to power update", 32'(n), 6);
    wait_release(n);
    chk("R7", "delay sequence ends", 32'(n != 0), 1);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    int n;
    wr(9'd126, 32'h82); wr(9'd127, 32'h20); wr(9'd0, 32'h00);
    wr(A_CTRL, 32'h0000_07E1);
    pulse_wfi();
    wait_release(n);
    chk("R9", "wrapped sequence ends", 32'(n != 0), 1);
    rd(A_STAT, d); chk("R9", "index wrapped to 0", d, 0);
    chk("R5", "no-op leaves power byte", 32'(pwr_ctl_o), 32'h02);
  endtask

  task automatic t_rewrite_and_abort();
    logic [31:0] d;
    int n;
    wr(9'd40, 32'h01); wr(9'd41, 32'h86); wr(9'd42, 32'h00);
    wr(A_CTRL, 32'h0000_0281);
    pulse_wfi();
    @(negedge clk);
    wr(A_CTRL, 32'h0000_0641);
    rd(A_STAT, d); chk("R11", "rewrite leaves running sequence", d, 32'h0000_0292);
    pulse_wake();
    wait_release(n);
    chk("R11", "original sequence completes", 32'(pwr_ctl_o), 32'h06);
    // abort
    wr(A_CTRL, 32'h0000_0281);
    pulse_wfi();
    @(negedge clk);
    rd(A_STAT, d); chk("R11", "waiting before abort", d & 32'h3, 2);
    wr(A_CTRL, 32'h0000_0280);
    @(negedge clk);
    chk("R11", "abort pulses release", 32'(release_o), 1);
    rd(A_STAT, d); chk("R11", "abort returns idle", d & 32'h3, 0);
    @(negedge clk);
    chk("R11", "abort release one cycle", 32'(release_o), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_addr = '0; reg_wr_data = '0;
    reg_rd_addr = '0; wfi_i = 1'b0; wake_irq_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_mem_and_ctrl();
    t_disabled();
    t_wait_seq();
    t_delay();
    t_wrap();
    t_rewrite_and_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule